// File: doc/BRIEF.md
# Weighted Two-Input Pixel Blender

This block crossfades two pixel streams. Every clock it takes one sample from stream A, one from stream B and a per-sample format flag, and produces the weighted mix `w·A + (1 − w)·B`. The weight `w` comes from a separately loadable coefficient register. Both samples share one format: signed two's complement or plain unsigned. The flag is captured with its samples and follows them down the pipeline. Samples with different formats can therefore be interleaved freely.

The coefficient is a fixed-point fraction whose top bit stands for unity. A loaded code above unity is pinned to exactly unity, and the register keeps its contents for as long as the load enable stays low. The weight can never exceed one, so the top integer bit of the internal sum carries no information. The block drops that bit, which shifts the result one place left. It then hands the kept integer bits and a set of fraction guard bits to a downstream rounder, together with the format flag of the sample. Every stage is registered, so one result leaves per clock at a fixed depth.

Top module: `pixel_blend`

## Requirements
- R1: With the default parameters, `mix_out` equals `wc·A + (2048 − wc)·B` as a 23-bit two's-complement or unsigned integer. Here `wc` is the clamped coefficient code and A, B are the extended samples. Bits 22:10 are the 13-bit result and bits 9:0 are guard bits.
- R2: The coefficient code is unsigned. Bit 11 weighs 1 and bits 10..0 weigh 2^-1..2^-11. For example, code 0x200 gives a weight of one quarter.
- R3: A captured coefficient code above 0x800 is used as exactly 0x800.
- R4: While `coef_load` is low, the coefficient register keeps its last captured code and ignores `coef_in`.
- R5: `fmt_unsigned` = 0 treats A and B as two's complement and sign-extends them. `fmt_unsigned` = 1 treats them as unsigned and zero-extends them.
- R6: The format flag is captured with its samples and appears on `mix_unsigned` alongside that sample's result. Changing it has no effect on samples already in flight.
- R7: A sample captured at clock edge k produces its result after edge k+3. New samples are accepted on every edge.
- R8: During reset, `mix_out` and `mix_unsigned` are zero and the coefficient register is zero. A sample entered after reset without a coefficient load therefore returns B.
- R9: Coefficient 0 returns exactly B·2048, and coefficient 0x800 returns exactly A·2048.
- R10: The internal sum bits above the 23 kept bits are pure sign or zero extension, so the result keeps its value after the top bit is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| coef_load | input | 1 | Captures `coef_in` into the coefficient register when high |
| coef_in | input | 12 | Mix coefficient code, unsigned, unity at 0x800 |
| fmt_unsigned | input | 1 | Sample format: 0 two's complement, 1 unsigned |
| pix_a | input | 12 | Stream A sample, weighted by the coefficient |
| pix_b | input | 12 | Stream B sample, weighted by its complement |
| mix_out | output | 23 | Blended result: 13 kept bits above 10 guard bits |
| mix_unsigned | output | 1 | Format flag of the sample now on `mix_out` |

## Verification
Two functions can fall in the same cycle: a coefficient load, possibly of an out-of-range code that must be pinned, and a change of the format flag. The streamed vector table therefore contains entries in which a fresh coefficient arrives in the same cycle as a format switch. It also has entries in which the format flips while the load enable is low. Each result is judged four edges later against a bench model that tracks the held coefficient separately and evaluates that sample with its own format, and `mix_unsigned` is compared on the same cycle.

// File: rtl/blend_pkg.sv
package blend_pkg;

   localparam int ARCH_DIFF   = 0;
   localparam int ARCH_DIRECT = 1;

   typedef enum logic {
      FMT_SIGNED   = 1'b0,
      FMT_UNSIGNED = 1'b1
   } fmt_e;

   function automatic int ext_width(input int data_w);
      return data_w + 1;
   endfunction

   function automatic int prod_width(input int data_w, input int coef_w);
      return ext_width(data_w) + 1 + coef_w + 1;
   endfunction

   function automatic int sum_width(input int data_w, input int coef_w);
      return prod_width(data_w, coef_w) + 1;
   endfunction

endpackage

// File: rtl/blend_coef_reg.sv
module blend_coef_reg #(
   parameter int COEF_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [COEF_W-1:0] coef_in,
   output logic [COEF_W-1:0] coef_clamped
);
   localparam logic [COEF_W-1:0] UNITY = COEF_W'(1) << (COEF_W - 1);

   logic [COEF_W-1:0] coef_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      coef_q <= '0;
      else if (load)   coef_q <= coef_in;
   end

   always_comb begin
      coef_clamped = (coef_q > UNITY) ? UNITY : coef_q;
   end

   p_clamp_unity_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (load && coef_in > UNITY) |=> (coef_clamped == UNITY));

   p_hold_coef_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(coef_clamped));

endmodule

// File: rtl/blend_input_stage.sv
module blend_input_stage #(
   parameter int DATA_W = 12,
   localparam int EXT_W = blend_pkg::ext_width(DATA_W)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    fmt_in,
   input  logic [DATA_W-1:0]       a_in,
   input  logic [DATA_W-1:0]       b_in,
   output logic                    fmt_q,
   output logic signed [EXT_W-1:0] a_ext,
   output logic signed [EXT_W-1:0] b_ext
);
   import blend_pkg::*;

   logic [DATA_W-1:0] a_q, b_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q   <= '0;
         b_q   <= '0;
         fmt_q <= 1'b0;
      end else begin
         a_q   <= a_in;
         b_q   <= b_in;
         fmt_q <= fmt_in;
      end
   end

   logic a_fill, b_fill;

   always_comb begin
      a_fill = (fmt_e'(fmt_q) == FMT_UNSIGNED) ? 1'b0 : a_q[DATA_W-1];
      b_fill = (fmt_e'(fmt_q) == FMT_UNSIGNED) ? 1'b0 : b_q[DATA_W-1];
      a_ext  = $signed({a_fill, a_q});
      b_ext  = $signed({b_fill, b_q});
   end

endmodule

// File: rtl/blend_core.sv
module blend_core #(
   parameter int DATA_W = 12,
   parameter int COEF_W = 12,
   parameter int ARCH   = blend_pkg::ARCH_DIFF,
   localparam int EXT_W  = blend_pkg::ext_width(DATA_W),
   localparam int SUM_W  = blend_pkg::sum_width(DATA_W, COEF_W)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [COEF_W-1:0]       coef,
   input  logic signed [EXT_W-1:0] a_ext,
   input  logic signed [EXT_W-1:0] b_ext,
   input  logic                    fmt_in,
   output logic signed [SUM_W-1:0] sum_q,
   output logic                    fmt_q
);
   localparam int CW1    = COEF_W + 1;
   localparam int DIFF_W = EXT_W + 1;
   localparam int PROD_W = blend_pkg::prod_width(DATA_W, COEF_W);
   localparam int PAD_W  = SUM_W - EXT_W - (COEF_W - 1);
   localparam logic [COEF_W-1:0] UNITY = COEF_W'(1) << (COEF_W - 1);

   // stage 2: registered operands
   logic [COEF_W-1:0]       coef_s2;
   logic signed [EXT_W-1:0] a_s2, b_s2;
   logic                    fmt_s2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coef_s2 <= '0;
         a_s2    <= '0;
         b_s2    <= '0;
         fmt_s2  <= 1'b0;
      end else begin
         coef_s2 <= coef;
         a_s2    <= a_ext;
         b_s2    <= b_ext;
         fmt_s2  <= fmt_in;
      end
   end

   logic signed [CW1-1:0]   coef_sv;
   logic signed [SUM_W-1:0] b_scaled;

   always_comb begin
      coef_sv  = $signed({1'b0, coef_s2});
      b_scaled = $signed({{PAD_W{b_s2[EXT_W-1]}}, b_s2, {(COEF_W-1){1'b0}}});
   end

   logic fmt_s3;

   generate
      if (ARCH == blend_pkg::ARCH_DIFF) begin : g_diff
         // w*A + (1-w)*B folded as B*unity + w*(A-B): one multiplier
         logic signed [DIFF_W-1:0] diff_c;
         logic signed [PROD_W-1:0] prod_c, prod_s3;
         logic signed [SUM_W-1:0]  base_s3;

         always_comb begin
            diff_c = {a_s2[EXT_W-1], a_s2} - {b_s2[EXT_W-1], b_s2};
            prod_c = diff_c * coef_sv;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prod_s3 <= '0;
               base_s3 <= '0;
               fmt_s3  <= 1'b0;
            end else begin
               prod_s3 <= prod_c;
               base_s3 <= b_scaled;
               fmt_s3  <= fmt_s2;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sum_q <= '0;
            else        sum_q <= {prod_s3[PROD_W-1], prod_s3} + base_s3;
         end
      end else begin : g_direct
         // two multipliers, one per weighted operand
         localparam int PW = EXT_W + CW1;
         logic signed [CW1-1:0] ncoef_sv;
         logic signed [PW-1:0]  pa_c, pb_c, pa_s3, pb_s3;

         always_comb begin
            ncoef_sv = $signed({1'b0, UNITY - coef_s2});
            pa_c     = a_s2 * coef_sv;
            pb_c     = b_s2 * ncoef_sv;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pa_s3  <= '0;
               pb_s3  <= '0;
               fmt_s3 <= 1'b0;
            end else begin
               pa_s3  <= pa_c;
               pb_s3  <= pb_c;
               fmt_s3 <= fmt_s2;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sum_q <= '0;
            else sum_q <= {{(SUM_W-PW){pa_s3[PW-1]}}, pa_s3}
                        + {{(SUM_W-PW){pb_s3[PW-1]}}, pb_s3};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fmt_q <= 1'b0;
      else        fmt_q <= fmt_s3;
   end

   p_zero_coef_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (coef_s2 == '0) |=> ##1 (sum_q == $past(b_scaled, 2)));

endmodule

// File: rtl/pixel_blend.sv
module pixel_blend #(
   parameter int DATA_W  = 12,
   parameter int COEF_W  = 12,
   parameter int GUARD_W = 10,
   parameter int ARCH    = blend_pkg::ARCH_DIFF,
   localparam int OUT_W  = DATA_W + 1 + GUARD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              coef_load,
   input  logic [COEF_W-1:0] coef_in,
   input  logic              fmt_unsigned,
   input  logic [DATA_W-1:0] pix_a,
   input  logic [DATA_W-1:0] pix_b,
   output logic [OUT_W-1:0]  mix_out,
   output logic              mix_unsigned
);
   localparam int EXT_W = blend_pkg::ext_width(DATA_W);
   localparam int SUM_W = blend_pkg::sum_width(DATA_W, COEF_W);
   localparam int SHIFT = COEF_W - 2 - GUARD_W;
   localparam int UP_W  = SUM_W - SHIFT - OUT_W;

   generate
      if (DATA_W < 2)  begin : g_bad_data  $error("DATA_W must be at least 2");  end
      if (COEF_W < 3)  begin : g_bad_coef  $error("COEF_W must be at least 3");  end
      if (GUARD_W < 0 || SHIFT < 0) begin : g_bad_guard
         $error("GUARD_W must lie in 0..COEF_W-2");
      end
      if (ARCH != blend_pkg::ARCH_DIFF && ARCH != blend_pkg::ARCH_DIRECT) begin : g_bad_arch
         $error("ARCH selects an unknown multiplier arrangement");
      end
   endgenerate

   logic [COEF_W-1:0]       coef_cl;
   logic signed [EXT_W-1:0] a_ext, b_ext;
   logic                    fmt_s1;
   logic signed [SUM_W-1:0] sum_q;

   blend_coef_reg #(.COEF_W(COEF_W)) u_coef (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (coef_load),
      .coef_in      (coef_in),
      .coef_clamped (coef_cl)
   );

   blend_input_stage #(.DATA_W(DATA_W)) u_in (
      .clk    (clk),
      .rst_n  (rst_n),
      .fmt_in (fmt_unsigned),
      .a_in   (pix_a),
      .b_in   (pix_b),
      .fmt_q  (fmt_s1),
      .a_ext  (a_ext),
      .b_ext  (b_ext)
   );

   blend_core #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ARCH(ARCH)) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .coef   (coef_cl),
      .a_ext  (a_ext),
      .b_ext  (b_ext),
      .fmt_in (fmt_s1),
      .sum_q  (sum_q),
      .fmt_q  (mix_unsigned)
   );

   // drop the redundant top bit(s): keep one extra integer LSB plus guards
   assign mix_out = sum_q[SHIFT +: OUT_W];

   // edges seen since reset release, saturating at the pipeline depth
   logic [2:0] warm;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          warm <= '0;
      else if (warm != 3'd4) warm <= warm + 3'd1;
   end

   p_fmt_travels_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 3'd4) |-> (mix_unsigned == $past(fmt_unsigned, 4)));

   p_msb_redundant_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mix_unsigned |-> (sum_q[SUM_W-1 -: UP_W] == '0));

   p_sign_redundant_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !mix_unsigned |-> (sum_q[SUM_W-1 -: UP_W] == {UP_W{sum_q[SHIFT+OUT_W-1]}}));

endmodule

// File: tb/pixel_blend_test.sv
module pixel_blend_test;
   localparam int CLK_PERIOD = 10;
   localparam int OUT_W = 23;
   localparam int NV = 12;

   // {fmt_unsigned, coef_load, coef, A, B}
   localparam logic [37:0] VEC [NV] = '{
      {1'b1, 1'b1, 12'h800, 12'h0FF, 12'h300},
      {1'b1, 1'b1, 12'h400, 12'h100, 12'h200},
      {1'b0, 1'b1, 12'h400, 12'hF00, 12'h100},
      {1'b0, 1'b0, 12'hFFF, 12'h7FF, 12'h800},
      {1'b0, 1'b1, 12'hFFF, 12'h7FF, 12'h800},
      {1'b1, 1'b0, 12'h000, 12'hFFF, 12'h000},
      {1'b0, 1'b1, 12'h001, 12'h800, 12'h7FF},
      {1'b1, 1'b1, 12'h001, 12'hFFF, 12'h000},
      {1'b1, 1'b1, 12'h801, 12'h123, 12'h456},
      {1'b0, 1'b1, 12'h000, 12'h123, 12'hABC},
      {1'b0, 1'b0, 12'h7FF, 12'hABC, 12'h123},
      {1'b1, 1'b1, 12'h555, 12'hABC, 12'h123}
   };

   logic clk = 1'b0;
   logic rst_n;
   logic coef_load;
   logic [11:0] coef_in, pix_a, pix_b;
   logic fmt_unsigned;
   logic [OUT_W-1:0] mix_out;
   logic mix_unsigned;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pixel_blend uut (
      .clk(clk), .rst_n(rst_n), .coef_load(coef_load), .coef_in(coef_in),
      .fmt_unsigned(fmt_unsigned), .pix_a(pix_a), .pix_b(pix_b),
      .mix_out(mix_out), .mix_unsigned(mix_unsigned)
   );

   function automatic logic [OUT_W-1:0] model(input logic fmt, input logic [11:0] w,
                                              input logic [11:0] a, input logic [11:0] b);
      longint wc, ea, eb, s;
      wc = (w > 12'h800) ? 2048 : longint'(w);
      ea = fmt ? longint'(a) : longint'($signed(a));
      eb = fmt ? longint'(b) : longint'($signed(b));
      s  = wc * ea + (2048 - wc) * eb;
      return s[OUT_W-1:0];
   endfunction

   function automatic string vtag(input logic [37:0] v, input logic prev_fmt);
      if (v[36] && v[35:24] > 12'h800) return "R3";
      if (!v[36])                      return "R4";
      if (v[37] != prev_fmt)           return "R6";
      return "R1";
   endfunction

   task automatic check_val(input string tag, input logic [OUT_W-1:0] got,
                            input logic [OUT_W-1:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: mix_out got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic check_bit(input string tag, input logic got, input logic exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: mix_unsigned got %b expected %b", tag, got, exp);
      end
   endtask

   task automatic put(input logic fmt, input logic ld, input logic [11:0] w,
                      input logic [11:0] a, input logic [11:0] b);
      fmt_unsigned = fmt; coef_load = ld; coef_in = w; pix_a = a; pix_b = b;
   endtask

   // hold one input set, then sample after four edges
   task automatic steady(input string tag, input logic fmt, input logic ld,
                         input logic [11:0] w, input logic [11:0] a, input logic [11:0] b,
                         input logic [OUT_W-1:0] exp);
      @(negedge clk);
      put(fmt, ld, w, a, b);
      repeat (4) @(negedge clk);
      check_val(tag, mix_out, exp);
      check_bit(tag, mix_unsigned, fmt);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL R7: watchdog expired, got hang expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      logic [OUT_W-1:0] exp_v [NV];
      logic             exp_f [NV];
      string            tags  [NV];
      logic [11:0]      m_coef;
      logic             prev_fmt;

      rst_n = 1'b0;
      put(1'b1, 1'b0, 12'hABC, 12'h0FF, 12'h200);
      repeat (3) @(negedge clk);
      // R8: reset state
      check_val("R8", mix_out, '0);
      check_bit("R8", mix_unsigned, 1'b0);
      rst_n = 1'b1;
      // R8: coefficient register is zero after reset, so B comes out
      repeat (4) @(negedge clk);
      check_val("R8", mix_out, 23'h100000);

      // streamed table: a new sample every clock
      m_coef = 12'h000;
      prev_fmt = 1'b1;
      for (int i = 0; i < NV + 4; i++) begin
         @(negedge clk);
         if (i >= 4) begin
            check_val(tags[i-4], mix_out, exp_v[i-4]);
            check_bit("R6", mix_unsigned, exp_f[i-4]);
         end
         if (i < NV) begin
            logic [37:0] v;
            v = VEC[i];
            if (v[36]) m_coef = v[35:24];
            exp_v[i] = model(v[37], m_coef, v[23:12], v[11:0]);
            exp_f[i] = v[37];
            tags[i]  = vtag(v, prev_fmt);
            prev_fmt = v[37];
            put(v[37], v[36], v[35:24], v[23:12], v[11:0]);
         end
      end

      // R2: quarter weight
      steady("R2", 1'b1, 1'b1, 12'h200, 12'h400, 12'h000, 23'h080000);
      // R5: same bits, two formats
      steady("R5", 1'b0, 1'b1, 12'h400, 12'hFFF, 12'h000, 23'h7FFC00);
      steady("R5", 1'b1, 1'b1, 12'h400, 12'hFFF, 12'h000, 23'h3FFC00);
      // R9: coefficient extremes
      steady("R9", 1'b0, 1'b1, 12'h000, 12'h7FF, 12'h800, 23'h400000);
      steady("R9", 1'b0, 1'b1, 12'h800, 12'h7FF, 12'h800, 23'h3FF800);
      // R10: full-scale unsigned keeps its top bit
      steady("R10", 1'b1, 1'b1, 12'h555, 12'hFFF, 12'hFFF, 23'h7FF800);
      // R4: loaded 0x100, then a different code with load low
      steady("R4", 1'b1, 1'b1, 12'h100, 12'h800, 12'h000, 23'h080000);
      steady("R4", 1'b1, 1'b0, 12'h7FF, 12'h800, 12'h000, 23'h080000);

      // R7: single impulse through a zero-filled pipeline
      steady("R7", 1'b1, 1'b1, 12'h800, 12'h000, 12'h000, 23'h000000);
      @(negedge clk);
      put(1'b1, 1'b1, 12'h800, 12'h010, 12'h000);
      @(negedge clk);
      put(1'b1, 1'b1, 12'h800, 12'h000, 12'h000);
      check_val("R7", mix_out, 23'h000000);
      @(negedge clk);
      check_val("R7", mix_out, 23'h000000);
      @(negedge clk);
      check_val("R7", mix_out, 23'h000000);
      @(negedge clk);
      check_val("R7", mix_out, 23'h008000);
      @(negedge clk);
      check_val("R7", mix_out, 23'h000000);

      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule